// File: doc/BRIEF.md
# Interrupt Trigger-Mode Register with Line Sensing

This block holds a 16-bit trigger-mode map for sixteen interrupt request lines and turns each raw request into a normalized, active-high pending signal. Software reaches the map through a byte-wide I/O port interface. It uses two adjacent port addresses. The lower address holds the mode bits of lines 0 to 7, and the next address holds lines 8 to 15. Bit n of the map belongs to line n. A 0 in that bit makes the line edge-sensitive with active-high polarity. A 1 makes it level-sensitive with active-low polarity. One bit therefore selects the trigger type and the polarity together.

Every request input passes through a two-flop synchronizer. A small per-line state machine then decides what to present on the pending output. It has three named states. EDGE_IDLE waits for a rising edge. EDGE_PEND holds a captured edge until an end-of-interrupt pulse for that line arrives. LEVEL passes the inverted synchronized input straight through, without latching. The transitions are:
- capture: EDGE_IDLE to EDGE_PEND on a rising edge.
- acknowledge: EDGE_PEND to EDGE_IDLE on an end-of-interrupt pulse with no new rising edge in the same cycle.
- to_level: either edge state to LEVEL when the mode bit reads 1.
- to_edge: LEVEL to EDGE_IDLE when the mode bit reads 0.

A mode change therefore always discards a stale captured edge. Lines 0, 1, 2, 8 and 13 must stay edge-triggered, so their map bits are fixed at 0.

Top module: `irq_trig_ctrl`

## Requirements
- R1: After reset the map reads 0x00 at both ports and every pending output is 0.
- R2: A write to the base address (0x4D0) loads map bits 7:0 and a write to base+1 (0x4D1) loads bits 15:8; each write leaves the other byte unchanged.
- R3: While the read strobe is high and the address is 0x4D0 or 0x4D1, read data shows that map byte in the same cycle; otherwise read data is 0x00.
- R4: Writes to any address other than 0x4D0 and 0x4D1 leave the map unchanged.
- R5: Map bits 0, 1, 2, 8 and 13 always read 0 and ignore writes (0xFF written low reads 0xF8, 0xFF written high reads 0xDE).
- R6: On a line whose mode bit is 0, a 0-to-1 input transition sets its pending output, which stays 1 after the input falls.
- R7: An end-of-interrupt pulse on a pending edge-mode line clears its pending output.
- R8: On a line whose mode bit is 1, the pending output is the inverse of the synchronized input and follows it both ways with no latching.
- R9: Changing a line's mode bit discards any captured edge; returning the line to edge mode with no new rising edge leaves its pending output at 0.
- R10: An end-of-interrupt pulse has no effect on a level-mode line or on a line with nothing pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 16 | I/O port address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte, combinational |
| irq_in | input | 16 | Raw interrupt request lines |
| eoi | input | 16 | End-of-interrupt pulses, one per line |
| irq_pend | output | 16 | Normalized active-high pending requests |

## Verification
The bench first raises every line while all lines are still in edge mode. It then switches most of them to level mode while their inputs sit inactive-high. A design that kept the captured edge across the mode change would leave those lines pending. A single write of 0xFF to each port checks the fixed-edge bits: a design that stored those bits would read back 0xFF instead of 0xF8 or 0xDE. Level lines are driven low and then released. End-of-interrupt is pulsed on level lines and on idle lines. A latching level path would stay asserted after the release. An acknowledge that reached the wrong line would clear a pending edge it does not own. A line is also moved from edge to level and back to edge. A design that rebuilt the edge detector from stale history would invent a new pending request.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

    typedef enum logic [1:0] {
        ST_EDGE_IDLE = 2'd0,
        ST_EDGE_PEND = 2'd1,
        ST_LEVEL     = 2'd2
    } sense_state_e;

endpackage

// File: rtl/trig_map_regs.sv
module trig_map_regs #(
    parameter int                    NUM_LINES       = 16,
    parameter int                    ADDR_W          = 16,
    parameter logic [ADDR_W-1:0]     BASE_ADDR       = 16'h04D0,
    parameter logic [NUM_LINES-1:0]  FIXED_EDGE_MASK = 16'h2107
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic                 io_rd,
    input  logic                 io_wr,
    input  logic [7:0]           io_wdata,
    output logic [7:0]           io_rdata,
    output logic [NUM_LINES-1:0] mode_map
);
    localparam int NUM_BYTES = NUM_LINES / 8;

    logic [NUM_BYTES-1:0] rd_hit;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        localparam logic [ADDR_W-1:0] BYTE_ADDR = BASE_ADDR + ADDR_W'(b);
        localparam logic [7:0]        WR_KEEP   = ~FIXED_EDGE_MASK[b*8 +: 8];

        logic [7:0] byte_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (io_wr && (io_addr == BYTE_ADDR)) begin
                byte_q <= io_wdata & WR_KEEP;
            end
        end

        assign mode_map[b*8 +: 8] = byte_q;
        assign rd_hit[b]          = io_rd && (io_addr == BYTE_ADDR);
    end

    always_comb begin
        io_rdata = '0;
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (rd_hit[b]) begin
                io_rdata = io_rdata | mode_map[b*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/irq_sync_vec.sv
module irq_sync_vec #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= async_in;
            end else begin
                stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/irq_line_sense.sv
module irq_line_sense
    import irq_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_lvl,
    input  logic req_sync,
    input  logic eoi,
    output logic pend
);
    sense_state_e state_q;
    sense_state_e state_d;
    logic         req_prev_q;
    logic         rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_prev_q <= 1'b0;
        end else begin
            req_prev_q <= req_sync;
        end
    end

    assign rise = req_sync && !req_prev_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EDGE_IDLE: begin
                if (mode_lvl)  state_d = ST_LEVEL;
                else if (rise) state_d = ST_EDGE_PEND;
            end
            ST_EDGE_PEND: begin
                if (mode_lvl)           state_d = ST_LEVEL;
                else if (eoi && !rise)  state_d = ST_EDGE_IDLE;
            end
            ST_LEVEL: begin
                if (!mode_lvl) state_d = ST_EDGE_IDLE;
            end
            default: state_d = ST_EDGE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EDGE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_EDGE_IDLE: pend = 1'b0;
            ST_EDGE_PEND: pend = 1'b1;
            ST_LEVEL:     pend = !req_sync;
            default:      pend = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_trig_ctrl.sv
module irq_trig_ctrl #(
    parameter int                    NUM_LINES       = 16,
    parameter int                    ADDR_W          = 16,
    parameter logic [ADDR_W-1:0]     BASE_ADDR       = 16'h04D0,
    parameter logic [NUM_LINES-1:0]  FIXED_EDGE_MASK = 16'h2107,
    parameter int                    SYNC_STAGES     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic                 io_rd,
    input  logic                 io_wr,
    input  logic [7:0]           io_wdata,
    output logic [7:0]           io_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] eoi,
    output logic [NUM_LINES-1:0] irq_pend
);
    logic [NUM_LINES-1:0] mode_map;
    logic [NUM_LINES-1:0] irq_sync;

    trig_map_regs #(
        .NUM_LINES       (NUM_LINES),
        .ADDR_W          (ADDR_W),
        .BASE_ADDR       (BASE_ADDR),
        .FIXED_EDGE_MASK (FIXED_EDGE_MASK)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .mode_map (mode_map)
    );

    irq_sync_vec #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (irq_sync)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        irq_line_sense u_sense (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_lvl (mode_map[i]),
            .req_sync (irq_sync[i]),
            .eoi      (eoi[i]),
            .pend     (irq_pend[i])
        );
    end

endmodule

// File: rtl/irq_trig_chk.sv
module irq_trig_chk #(
    parameter int                    NUM_LINES       = 16,
    parameter int                    ADDR_W          = 16,
    parameter logic [ADDR_W-1:0]     BASE_ADDR       = 16'h04D0,
    parameter logic [NUM_LINES-1:0]  FIXED_EDGE_MASK = 16'h2107
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    io_addr,
    input logic                 io_rd,
    input logic                 io_wr,
    input logic [7:0]           io_rdata,
    input logic [NUM_LINES-1:0] eoi,
    input logic [NUM_LINES-1:0] irq_pend,
    input logic [NUM_LINES-1:0] mode_map
);
    localparam int NUM_BYTES = NUM_LINES / 8;

    logic wr_in_range;
    assign wr_in_range = io_wr && (io_addr >= BASE_ADDR) &&
                         (io_addr < BASE_ADDR + ADDR_W'(NUM_BYTES));

    // R3
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (io_rdata == 8'h00));

    // R4
    map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_in_range |=> $stable(mode_map));

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte_chk
        localparam logic [ADDR_W-1:0] BYTE_ADDR = BASE_ADDR + ADDR_W'(b);
        localparam logic [7:0]        FIX_BITS  = FIXED_EDGE_MASK[b*8 +: 8];
        // R5
        fixed_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (io_rd && io_addr == BYTE_ADDR) |-> ((io_rdata & FIX_BITS) == 8'h00));
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line_chk
        // R6
        edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_pend[i] && !mode_map[i] && $stable(mode_map[i]) && !eoi[i])
            |=> irq_pend[i]);
    end

endmodule

bind irq_trig_ctrl irq_trig_chk #(
    .NUM_LINES       (NUM_LINES),
    .ADDR_W          (ADDR_W),
    .BASE_ADDR       (BASE_ADDR),
    .FIXED_EDGE_MASK (FIXED_EDGE_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_rdata (io_rdata),
    .eoi      (eoi),
    .irq_pend (irq_pend),
    .mode_map (mode_map)
);

// File: tb/tb_irq_trig_ctrl.sv
module tb_irq_trig_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [15:0] LO_PORT = 16'h04D0;
    localparam logic [15:0] HI_PORT = 16'h04D1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [15:0] irq_in = '0;
    logic [15:0] eoi = '0;
    logic [15:0] irq_pend;

    typedef struct {
        string       req;
        bit          is_rd;
        logic [15:0] exp;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_trig_ctrl dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .irq_in   (irq_in),
        .eoi      (eoi),
        .irq_pend (irq_pend)
    );

    // monitor: pops one expected item per falling edge and compares
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                logic [15:0] act;
                it  = sb_q.pop_front();
                act = it.is_rd ? {8'h00, io_rdata} : irq_pend;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s %s actual=%h expected=%h", it.req,
                             it.is_rd ? "rdata" : "pend", act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic push(input string req, input bit is_rd, input logic [15:0] exp);
        sb_item_t it;
        it.req = req; it.is_rd = is_rd; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic port_write(input logic [15:0] a, input logic [7:0] d);
        tick();
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        tick();
        io_wr = 1'b0;
    endtask

    task automatic port_read(input logic [15:0] a, input logic [7:0] exp, input string req);
        tick();
        io_addr = a; io_rd = 1'b1;
        push(req, 1'b1, {8'h00, exp});
        tick();
        io_rd = 1'b0;
    endtask

    task automatic pend_chk(input logic [15:0] exp, input string req);
        tick();
        push(req, 1'b0, exp);
    endtask

    task automatic eoi_pulse(input int line);
        tick();
        eoi[line] = 1'b1;
        tick();
        eoi[line] = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        pend_chk(16'h0000, "R1");
        port_read(LO_PORT, 8'h00, "R1");
        port_read(HI_PORT, 8'h00, "R1");

        // R6: all lines edge; raise the future level lines
        irq_in = 16'hDEF8;
        idle(5);
        pend_chk(16'hDEF8, "R6");
        irq_in = 16'h0000;
        idle(5);
        pend_chk(16'hDEF8, "R6");
        irq_in = 16'hDEF8;
        idle(5);

        // R2/R5/R9: low byte to level, high byte still captured
        port_write(LO_PORT, 8'hFF);
        port_read(LO_PORT, 8'hF8, "R5");
        port_read(HI_PORT, 8'h00, "R2");
        idle(3);
        pend_chk(16'hDE00, "R9");
        port_write(HI_PORT, 8'hFF);
        port_read(HI_PORT, 8'hDE, "R5");
        port_read(LO_PORT, 8'hF8, "R2");
        idle(3);
        pend_chk(16'h0000, "R9");

        // R4: neighbouring addresses
        port_write(16'h04D2, 8'h00);
        port_write(16'h04CF, 8'h00);
        port_write(16'h00D0, 8'h00);
        port_read(LO_PORT, 8'hF8, "R4");
        port_read(HI_PORT, 8'hDE, "R4");

        // R3: no strobe / off-map read
        tick();
        io_addr = LO_PORT; io_rd = 1'b0;
        push("R3", 1'b1, 16'h0000);
        port_read(16'h04D2, 8'h00, "R3");

        // R6/R7/R10: fixed edge line 0
        irq_in[0] = 1'b1;
        idle(5);
        pend_chk(16'h0001, "R6");
        irq_in[0] = 1'b0;
        idle(5);
        pend_chk(16'h0001, "R6");
        eoi_pulse(13);
        idle(2);
        pend_chk(16'h0001, "R10");
        eoi_pulse(0);
        idle(2);
        pend_chk(16'h0000, "R7");

        // R8/R10: level line 5
        irq_in[5] = 1'b0;
        idle(4);
        pend_chk(16'h0020, "R8");
        eoi_pulse(5);
        idle(2);
        pend_chk(16'h0020, "R10");
        irq_in[5] = 1'b1;
        idle(4);
        pend_chk(16'h0000, "R8");

        // R9: line 6 edge -> level -> edge
        port_write(LO_PORT, 8'h00);
        idle(3);
        pend_chk(16'h0000, "R9");
        irq_in[6] = 1'b0;
        idle(4);
        irq_in[6] = 1'b1;
        idle(5);
        pend_chk(16'h0040, "R6");
        port_write(LO_PORT, 8'h40);
        idle(3);
        pend_chk(16'h0000, "R9");
        port_write(LO_PORT, 8'h00);
        idle(4);
        pend_chk(16'h0000, "R9");

        idle(3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1..R10 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule